// File: doc/BRIEF.md
# Buffered Complementary PWM Period Generator

This block produces the triangle carrier for a complementary PWM timer. It has two up/down counters. The leading counter sits a fixed dead-time value above the lagging counter, and both climb and fall in step. Each counter has its own active upper limit. The leading limit must equal the lagging limit plus the dead time.

Software never writes the active limits. It writes two buffer registers, one per limit, through write-enable ports. The block copies both buffers into the active limits in a single clock at a carrier crest, a trough, or both, as a mode input selects.

- A period loaded at a crest first shapes the next carrier cycle.
- A period loaded at a trough shapes the cycle now starting.

While the start input is low, the counters rest at their initial values and the active limits follow the buffers directly.

Top module: `cpwm_period_gen`

## Requirements
- R1: While start_i is low, one clock later lag_cnt_o is 0, lead_cnt_o equals dead_i, and crest_o, trough_o and xfer_o are low. Reset clears both counters to 0 and asserts cfg_err_o.
- R2: Starting from the idle state with start_i high, both counters rise by one per clock. At the lagging limit L they turn and fall by one per clock back to 0, then rise again, giving a 2*L clock carrier.
- R3: While running, lead_cnt_o minus lag_cnt_o always equals dead_i.
- R4: crest_o is high for exactly the one clock in which the counters are rising and lead_cnt_o equals the leading limit. trough_o is high for the one clock in which they are falling and lag_cnt_o is 0. The first clock after start gives no trough.
- R5: While running, the active limits change only in a clock where xfer_o is high. Writing a buffer alone has no effect until then, so cfg_err_o is unchanged.
- R6: mode_i selects the transfer point: 2'b01 crest only, 2'b10 trough only, 2'b11 both, 2'b00 never. xfer_o is high in the same clock as the selected strobe.
- R7: A transfer at a crest leaves the falling half that follows unchanged. The next rise stops at the new lagging limit.
- R8: A transfer at a trough applies the new lagging limit to the rise that follows immediately.
- R9: A buffer write in the same clock as a transfer copies the newly written value into the active limit.
- R10: While start_i is low, every buffer write also loads the matching active limit, which shows on cfg_err_o one clock later.
- R11: cfg_err_o is high when the active leading limit differs from the active lagging limit plus dead_i, or when the active lagging limit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous run enable |
| mode_i | input | 2 | Transfer point select |
| dead_i | input | W | Dead-time offset between the counters |
| lead_we_i | input | 1 | Write enable for the leading-limit buffer |
| lead_wd_i | input | W | Leading-limit buffer write data |
| lag_we_i | input | 1 | Write enable for the lagging-limit buffer |
| lag_wd_i | input | W | Lagging-limit buffer write data |
| lead_cnt_o | output | W | Leading counter value |
| lag_cnt_o | output | W | Lagging counter value |
| crest_o | output | 1 | Crest strobe |
| trough_o | output | 1 | Trough strobe |
| xfer_o | output | 1 | Buffer-to-active transfer strobe |
| cfg_err_o | output | 1 | Limit relation error |

## Verification
The offset and step properties assume the following about the inputs:
- dead_i changes only while start_i is low.
- A run always begins from at least one idle clock.
- The active limits satisfy the relation of R11.

The stimulus meets these by changing the dead time and any inconsistent buffer pair only while idle. Every period it loads while running is consistent, with a lagging limit of at least 1. Each scenario first spends a few clocks idle before start_i rises.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    XFER_OFF    = 2'b00,
    XFER_CREST  = 2'b01,
    XFER_TROUGH = 2'b10,
    XFER_BOTH   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/cpwm_lim_bank.sv
module cpwm_lim_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         xfer_i,
  input  logic [W-1:0] dead_i,
  input  logic         lead_we_i,
  input  logic [W-1:0] lead_wd_i,
  input  logic         lag_we_i,
  input  logic [W-1:0] lag_wd_i,
  output logic [W-1:0] lead_lim_o,
  output logic [W-1:0] lag_lim_o,
  output logic         cfg_err_o
);
  logic [W-1:0] lead_buf_q, lag_buf_q;
  logic [W-1:0] lead_nxt, lag_nxt;
  logic         load;

  // a write in the transfer clock wins over the held buffer
  assign lead_nxt = lead_we_i ? lead_wd_i : lead_buf_q;
  assign lag_nxt  = lag_we_i  ? lag_wd_i  : lag_buf_q;
  assign load     = !run_i || xfer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_buf_q <= '0;
      lag_buf_q  <= '0;
      lead_lim_o <= '0;
      lag_lim_o  <= '0;
    end else begin
      lead_buf_q <= lead_nxt;
      lag_buf_q  <= lag_nxt;
      if (load) begin
        lead_lim_o <= lead_nxt;
        lag_lim_o  <= lag_nxt;
      end
    end
  end

  logic [W-1:0] lag_plus_dead;
  assign lag_plus_dead = lag_lim_o + dead_i;
  assign cfg_err_o     = (lead_lim_o != lag_plus_dead) || (lag_lim_o == '0);

  // R5
  lim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !xfer_i) |=> ($stable(lead_lim_o) && $stable(lag_lim_o)));

  // R9
  lim_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && xfer_i && lead_we_i && lag_we_i) |=>
      ((lead_lim_o == $past(lead_wd_i)) && (lag_lim_o == $past(lag_wd_i))));
endmodule

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] dead_i,
  input  logic [W-1:0] lead_lim_i,
  output logic [W-1:0] lead_o,
  output logic [W-1:0] lag_o,
  output logic         crest_o,
  output logic         trough_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic up_q;

  assign crest_o  = run_i && up_q  && (lead_o == lead_lim_i);
  assign trough_o = run_i && !up_q && (lag_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_o <= '0;
      lag_o  <= '0;
      up_q   <= 1'b1;
    end else if (!run_i) begin
      lead_o <= dead_i;
      lag_o  <= '0;
      up_q   <= 1'b1;
    end else if (crest_o) begin
      up_q   <= 1'b0;
      lead_o <= lead_o - ONE;
      lag_o  <= lag_o - ONE;
    end else if (trough_o || up_q) begin
      up_q   <= 1'b1;
      lead_o <= lead_o + ONE;
      lag_o  <= lag_o + ONE;
    end else begin
      lead_o <= lead_o - ONE;
      lag_o  <= lag_o - ONE;
    end
  end

  // marks that the counters were aligned by an idle clock
  logic aligned_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     aligned_q <= 1'b0;
    else if (!run_i) aligned_q <= 1'b1;
  end

  // R1
  idle_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((lag_o == '0) && (lead_o == $past(dead_i)) && !crest_o && !trough_o));

  // R3
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned_q && $stable(dead_i)) |-> ((lead_o - lag_o) == dead_i));

  // R2
  crest_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crest_o |=> (lag_o == $past(lag_o) - ONE));

  // R2
  trough_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trough_o |=> (lag_o == ONE));
endmodule

// File: rtl/cpwm_period_gen.sv
module cpwm_period_gen
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] dead_i,
  input  logic         lead_we_i,
  input  logic [W-1:0] lead_wd_i,
  input  logic         lag_we_i,
  input  logic [W-1:0] lag_wd_i,
  output logic [W-1:0] lead_cnt_o,
  output logic [W-1:0] lag_cnt_o,
  output logic         crest_o,
  output logic         trough_o,
  output logic         xfer_o,
  output logic         cfg_err_o
);
  xfer_mode_e   mode;
  logic         at_crest, at_trough;
  logic [W-1:0] lead_lim, lag_lim;

  assign mode = xfer_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      XFER_CREST:  xfer_o = crest_o;
      XFER_TROUGH: xfer_o = trough_o;
      XFER_BOTH:   xfer_o = crest_o || trough_o;
      default:     xfer_o = 1'b0;
    endcase
  end

  assign at_crest  = crest_o;
  assign at_trough = trough_o;

  cpwm_lim_bank #(.W(W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (start_i),
    .xfer_i     (xfer_o),
    .dead_i     (dead_i),
    .lead_we_i  (lead_we_i),
    .lead_wd_i  (lead_wd_i),
    .lag_we_i   (lag_we_i),
    .lag_wd_i   (lag_wd_i),
    .lead_lim_o (lead_lim),
    .lag_lim_o  (lag_lim),
    .cfg_err_o  (cfg_err_o)
  );

  cpwm_tri_cnt #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (start_i),
    .dead_i     (dead_i),
    .lead_lim_i (lead_lim),
    .lead_o     (lead_cnt_o),
    .lag_o      (lag_cnt_o),
    .crest_o    (crest_o),
    .trough_o   (trough_o)
  );

  // R6
  no_xfer_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> !xfer_o);

  // R6
  xfer_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> ((at_crest && mode_i[0]) || (at_trough && mode_i[1])));

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(at_crest && at_trough));
endmodule

// File: tb/cpwm_period_gen_tb.sv
`timescale 1ns/1ps
module cpwm_period_gen_tb;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   mode_i = 2'b01;
  logic [W-1:0] dead_i = W'(2);
  logic         lead_we_i = 1'b0, lag_we_i = 1'b0;
  logic [W-1:0] lead_wd_i = '0, lag_wd_i = '0;
  logic [W-1:0] lead_cnt_o, lag_cnt_o;
  logic         crest_o, trough_o, xfer_o, cfg_err_o;

  always #10 clk_i = ~clk_i;

  cpwm_period_gen #(.W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .dead_i(dead_i), .lead_we_i(lead_we_i), .lead_wd_i(lead_wd_i),
    .lag_we_i(lag_we_i), .lag_wd_i(lag_wd_i), .lead_cnt_o(lead_cnt_o),
    .lag_cnt_o(lag_cnt_o), .crest_o(crest_o), .trough_o(trough_o),
    .xfer_o(xfer_o), .cfg_err_o(cfg_err_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench reference state
  logic [W-1:0] m_lead, m_lag, m_llim, m_glim, m_bl, m_bg;
  logic         m_up, s_crest, s_trough;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: settle, compare, advance reference, reach next negedge
  task automatic cyc();
    logic mc, mt, mx, me;
    logic [W-1:0] nl, ng;
    #1;
    mc = start_i && m_up && (m_lead == m_llim);
    mt = start_i && !m_up && (m_lag == '0);
    mx = (mode_i[0] && mc) || (mode_i[1] && mt);
    me = (m_llim != m_glim + dead_i) || (m_glim == '0);
    chk(lead_cnt_o == m_lead, "R2 lead", int'(lead_cnt_o), int'(m_lead));
    chk(lag_cnt_o == m_lag, "R2 lag", int'(lag_cnt_o), int'(m_lag));
    chk(crest_o == mc, "R4 crest", int'(crest_o), int'(mc));
    chk(trough_o == mt, "R4 trough", int'(trough_o), int'(mt));
    chk(xfer_o == mx, "R6 xfer", int'(xfer_o), int'(mx));
    chk(cfg_err_o == me, "R11 cfg", int'(cfg_err_o), int'(me));
    if (start_i)
      chk(W'(lead_cnt_o - lag_cnt_o) == dead_i, "R3 offset",
          int'(W'(lead_cnt_o - lag_cnt_o)), int'(dead_i));
    s_crest = mc;
    s_trough = mt;
    nl = lead_we_i ? lead_wd_i : m_bl;
    ng = lag_we_i ? lag_wd_i : m_bg;
    m_bl = nl;
    m_bg = ng;
    if (!start_i) begin
      m_lead = dead_i; m_lag = '0; m_up = 1'b1; m_llim = nl; m_glim = ng;
    end else begin
      if (mx) begin m_llim = nl; m_glim = ng; end
      if (mc) begin m_up = 1'b0; m_lead--; m_lag--; end
      else if (mt || m_up) begin m_up = 1'b1; m_lead++; m_lag++; end
      else begin m_lead--; m_lag--; end
    end
    @(negedge clk_i);
  endtask

  task automatic put(input bit le, input int lv, input bit ge, input int gv);
    lead_we_i = le; lead_wd_i = W'(lv);
    lag_we_i = ge; lag_wd_i = W'(gv);
    cyc();
    lead_we_i = 1'b0; lag_we_i = 1'b0;
  endtask

  task automatic run_until(input bit want_crest, output int n);
    n = 0;
    do begin
      cyc();
      n++;
    end while (!(want_crest ? s_crest : s_trough) && n < 200);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_lead = '0; m_lag = '0; m_up = 1'b1;
    m_llim = '0; m_glim = '0; m_bl = '0; m_bg = '0;
    #1;
    chk(lead_cnt_o == '0 && lag_cnt_o == '0, "R1 reset cnt", int'(lead_cnt_o), 0);
    chk(cfg_err_o == 1'b1, "R1 reset err", int'(cfg_err_o), 1);
  endtask

  task automatic t_idle();
    cyc();
    chk(lead_cnt_o == W'(2) && lag_cnt_o == '0, "R1 idle", int'(lead_cnt_o), 2);
    put(1, 8, 1, 3);
    cyc();
    chk(cfg_err_o == 1'b1, "R11 mismatch", int'(cfg_err_o), 1);
    put(1, 2, 1, 0);
    cyc();
    chk(cfg_err_o == 1'b1, "R11 zero lag", int'(cfg_err_o), 1);
    put(1, 5, 1, 3);
    cyc();
    chk(cfg_err_o == 1'b0, "R10 direct load", int'(cfg_err_o), 0);
  endtask

  task automatic t_start();
    int n;
    mode_i = 2'b01;
    start_i = 1'b1;
    run_until(1, n);
    chk(n == 4, "R2 first crest", n, 4);
    run_until(0, n);
    chk(n == 3, "R2 fall", n, 3);
  endtask

  task automatic t_crest_load();
    int n;
    put(1, 7, 0, 0);
    chk(cfg_err_o == 1'b0, "R5 buffer only", int'(cfg_err_o), 0);
    put(0, 0, 1, 5);
    run_until(1, n);
    chk(n == 1, "R7 crest at old", n, 1);
    run_until(0, n);
    chk(n == 3, "R7 fall unchanged", n, 3);
    run_until(1, n);
    chk(n == 5, "R7 new rise", n, 5);
  endtask

  task automatic t_trough_load();
    int n;
    mode_i = 2'b10;
    put(1, 4, 1, 2);
    run_until(0, n);
    chk(n == 4, "R8 fall old", n, 4);
    run_until(1, n);
    chk(n == 2, "R8 same cycle", n, 2);
  endtask

  task automatic t_off();
    int n;
    bit seen;
    mode_i = 2'b00;
    put(1, 9, 1, 7);
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (xfer_o) seen = 1'b1;
      cyc();
    end
    chk(!seen, "R6 off", int'(seen), 0);
    run_until(1, n);
    run_until(0, n);
    chk(n == 2, "R6 period kept", n, 2);
  endtask

  task automatic t_same_clk();
    int n;
    mode_i = 2'b11;
    while (!(start_i && !m_up && m_lag == '0)) cyc();
    put(1, 6, 1, 4);
    chk(s_trough == 1'b1, "R9 at trough", int'(s_trough), 1);
    run_until(1, n);
    chk(n == 4, "R9 new value", n, 4);
    run_until(0, n);
    chk(n == 4, "R9 fall", n, 4);
  endtask

  task automatic t_stop();
    start_i = 1'b0;
    cyc();
    chk(lead_cnt_o == W'(2) && lag_cnt_o == '0 && !crest_o && !trough_o,
        "R1 stop", int'(lag_cnt_o), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_start();
    t_crest_load();
    t_trough_load();
    t_off();
    t_same_clk();
    t_stop();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule